// File: doc/BRIEF.md
# Data Translation Buffer with Access Fault Check

This block is a fully associative data translation buffer. Every entry is compared with each incoming data access at once. The block then decides whether the access may proceed, raises a data-access fault, or raises a write-protection fault. The access request carries a virtual page, an address-space context, a user/privileged mode bit and an access kind. The kind is a normal load, a store, or a nonfaulting load, which is a speculative read that must never touch a side-effecting page. Entries are loaded through a synchronous write port addressed by entry index. Each entry takes a 64-bit attribute word, a tag and a physical page.

The block treats a nonfaulting load differently from every other access. A page marked "nonfaulting loads only" faults on any other kind of access. A page marked "side-effect" faults on a nonfaulting load. A privileged page faults on a user-mode access. Each of these conditions sets its own cause bit in a fault status word, and several can be set together. Any data-access condition overrides the write-protection check. The result appears one clock after the request strobe.

Top module: `dtlb_fault_check`

## Requirements
- R1: While reset is high and on the first cycle after it, `rsp_valid` and every other output are low. After reset no entry is valid.
- R2: A request strobed with `req_valid` in cycle N produces `rsp_valid` high in cycle N+1 only. Whenever `rsp_valid` is low, all other outputs are low.
- R3: A hit needs an entry whose valid bit is set, whose virtual page equals `req_vpn` and whose context equals `req_ctx`. A hit returns that entry's physical page on `rsp_ppn`. With no such entry, `rsp_miss` is high, `rsp_fault` is 0, no permission is granted, and `rsp_ppn` is 0.
- R4: The attribute word is decoded as follows: bit 63 valid, bit 60 nonfaulting-only, bit 3 side-effect, bit 2 privileged, bit 1 writable. All other bits have no effect. A write in cycle N is seen by lookups from cycle N+1 on. A lookup in cycle N sees the old contents.
- R5: A user-mode access (`req_user`=1) that hits a privileged entry sets cause bit 2 of `rsp_fsw` and gives `rsp_fault`=1 (data-access fault).
- R6: A nonfaulting load that hits a side-effect entry sets cause bit 3 of `rsp_fsw` and gives `rsp_fault`=1.
- R7: Any access other than a nonfaulting load that hits a nonfaulting-only entry sets cause bit 4 of `rsp_fsw` and gives `rsp_fault`=1.
- R8: The cause bits are evaluated independently, so one data-access fault can report more than one of them.
- R9: A store that hits an entry with the writable bit clear gives `rsp_fault`=2 (write protection), but only when no data-access condition applies. A data-access condition gives code 1 instead.
- R10: On every response, `rsp_fsw` bit 0 is set for a store and bit 1 is set for a nonfaulting load.
- R11: A hit with no fault sets `rsp_rd_ok`, and sets `rsp_wr_ok` exactly when the entry is writable. A faulting access grants neither.
- R12: `req_kind` encodes 00 as normal load, 01 as store and 10 as nonfaulting load. Code 11 behaves as a normal load.
- R13: When several valid entries match, the entry with the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page of the access |
| req_ctx | input | CTX_W | Context of the access |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_kind | input | 2 | Access kind (R12) |
| wr_en | input | 1 | Entry write enable |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | VPN_W | Virtual page tag for the entry |
| wr_ctx | input | CTX_W | Context tag for the entry |
| wr_ppn | input | PPN_W | Physical page for the entry |
| wr_attr | input | 64 | Entry attribute word (R4) |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | A valid entry matched |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_ppn | output | PPN_W | Translated physical page |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_fault | output | 2 | 0 none, 1 data-access fault, 2 write-protection fault |
| rsp_fsw | output | 5 | Fault status: bit0 store, bit1 nonfaulting, bit2 privilege, bit3 side-effect, bit4 nonfaulting-only |

## Verification
Directed entries cover each attribute on its own and in pairs. Each is tried with user and privileged loads, stores, nonfaulting loads and the spare kind code. These runs separate the three cause bits, their combination in a single fault, and the override of write protection by a data-access condition. Further directed cases check a context mismatch, a cleared valid bit, duplicate tags at two indices, and a write to an entry in the same cycle as a lookup of its page. A long random phase then loads a small page set with random attribute words, including junk in the undecoded bits, and compares every cycle against a behavioural model.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int ATTR_W      = 64;
    localparam int BIT_VALID   = 63;
    localparam int BIT_NFO     = 60;
    localparam int BIT_SIDEFX  = 3;
    localparam int BIT_PRIV    = 2;
    localparam int BIT_WRITE   = 1;

    typedef enum logic [1:0] {
        KIND_LOAD   = 2'b00,
        KIND_STORE  = 2'b01,
        KIND_NFLOAD = 2'b10,
        KIND_SPARE  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_DACC  = 2'd1,
        FLT_DPROT = 2'd2
    } fault_e;

    // packed MSB first: bit4 .. bit0
    typedef struct packed {
        logic nfo_cause;
        logic sidefx_cause;
        logic priv_cause;
        logic nf_flag;
        logic st_flag;
    } fsw_t;

    typedef struct packed {
        logic valid;
        logic nfo;
        logic sidefx;
        logic priv;
        logic writable;
    } attr_t;

    function automatic attr_t decode_attr(input logic [ATTR_W-1:0] word);
        attr_t a;
        a.valid    = word[BIT_VALID];
        a.nfo      = word[BIT_NFO];
        a.sidefx   = word[BIT_SIDEFX];
        a.priv     = word[BIT_PRIV];
        a.writable = word[BIT_WRITE];
        return a;
    endfunction

endpackage

// File: rtl/dtlb_entry_array.sv
module dtlb_entry_array
    import dtlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int VPN_W     = 20,
    parameter int CTX_W     = 13,
    parameter int PPN_W     = 24,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [VPN_W-1:0]     wr_vpn,
    input  logic [CTX_W-1:0]     wr_ctx,
    input  logic [PPN_W-1:0]     wr_ppn,
    input  logic [ATTR_W-1:0]    wr_attr,
    input  logic [VPN_W-1:0]     lk_vpn,
    input  logic [CTX_W-1:0]     lk_ctx,
    output logic [N_ENTRIES-1:0] match_vec,
    output attr_t                attr_q [N_ENTRIES],
    output logic [PPN_W-1:0]     ppn_q  [N_ENTRIES]
);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        logic [VPN_W-1:0] vpn_r;
        logic [CTX_W-1:0] ctx_r;
        logic [PPN_W-1:0] ppn_r;
        attr_t            attr_r;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                vpn_r  <= '0;
                ctx_r  <= '0;
                ppn_r  <= '0;
                attr_r <= '0;
            end else if (sel) begin
                vpn_r  <= wr_vpn;
                ctx_r  <= wr_ctx;
                ppn_r  <= wr_ppn;
                attr_r <= decode_attr(wr_attr);
            end
        end

        assign match_vec[g] = attr_r.valid && (vpn_r == lk_vpn) && (ctx_r == lk_ctx);
        assign attr_q[g]    = attr_r;
        assign ppn_q[g]     = ppn_r;
    end

endmodule

// File: rtl/dtlb_hit_select.sv
module dtlb_hit_select
    import dtlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int PPN_W     = 24
) (
    input  logic [N_ENTRIES-1:0] match_vec,
    input  attr_t                attr_q [N_ENTRIES],
    input  logic [PPN_W-1:0]     ppn_q  [N_ENTRIES],
    output logic                 hit,
    output attr_t                sel_attr,
    output logic [PPN_W-1:0]     sel_ppn
);

    logic [N_ENTRIES-1:0] first_oh;

    // lowest index wins
    always_comb begin
        logic found;
        found    = 1'b0;
        first_oh = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (match_vec[i] && !found) begin
                first_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
    end

    always_comb begin
        sel_attr = '0;
        sel_ppn  = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (first_oh[i]) begin
                sel_attr = sel_attr | attr_q[i];
                sel_ppn  = sel_ppn  | ppn_q[i];
            end
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/dtlb_perm_check.sv
module dtlb_perm_check
    import dtlb_pkg::*;
(
    input  logic      hit,
    input  attr_t     attr,
    input  logic      user,
    input  logic [1:0] kind,
    output fault_e    fault,
    output fsw_t      fsw,
    output logic      rd_ok,
    output logic      wr_ok
);

    logic is_store, is_nf, dacc, dprot;

    assign is_store = (acc_kind_e'(kind) == KIND_STORE);
    assign is_nf    = (acc_kind_e'(kind) == KIND_NFLOAD);

    always_comb begin
        fsw              = '0;
        fsw.st_flag      = is_store;
        fsw.nf_flag      = is_nf;
        fsw.priv_cause   = hit && user && attr.priv;
        fsw.sidefx_cause = hit && is_nf && attr.sidefx;
        fsw.nfo_cause    = hit && !is_nf && attr.nfo;
    end

    assign dacc  = fsw.priv_cause || fsw.sidefx_cause || fsw.nfo_cause;
    assign dprot = hit && !dacc && is_store && !attr.writable;

    always_comb begin
        if (dacc)       fault = FLT_DACC;
        else if (dprot) fault = FLT_DPROT;
        else            fault = FLT_NONE;
    end

    assign rd_ok = hit && !dacc && !dprot;
    assign wr_ok = rd_ok && attr.writable;

endmodule

// File: rtl/dtlb_fault_check.sv
module dtlb_fault_check
    import dtlb_pkg::*;
#(
    parameter int N_ENTRIES = 64,
    parameter int VPN_W     = 20,
    parameter int CTX_W     = 13,
    parameter int PPN_W     = 24,
    localparam int IDX_W    = $clog2(N_ENTRIES),
    localparam int FSW_W    = $bits(fsw_t)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_user,
    input  logic [1:0]        req_kind,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [CTX_W-1:0]  wr_ctx,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [63:0]       wr_attr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_rd_ok,
    output logic              rsp_wr_ok,
    output logic [1:0]        rsp_fault,
    output logic [FSW_W-1:0]  rsp_fsw
);

    logic [N_ENTRIES-1:0] match_vec;
    attr_t                attr_q [N_ENTRIES];
    logic [PPN_W-1:0]     ppn_q  [N_ENTRIES];
    logic                 hit;
    attr_t                sel_attr;
    logic [PPN_W-1:0]     sel_ppn;
    fault_e               fault_c;
    fsw_t                 fsw_c;
    logic                 rd_c, wr_c;

    dtlb_entry_array #(
        .N_ENTRIES(N_ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .PPN_W(PPN_W)
    ) u_array (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ctx(wr_ctx),
        .wr_ppn(wr_ppn), .wr_attr(wr_attr),
        .lk_vpn(req_vpn), .lk_ctx(req_ctx),
        .match_vec(match_vec), .attr_q(attr_q), .ppn_q(ppn_q)
    );

    dtlb_hit_select #(
        .N_ENTRIES(N_ENTRIES), .PPN_W(PPN_W)
    ) u_select (
        .match_vec(match_vec), .attr_q(attr_q), .ppn_q(ppn_q),
        .hit(hit), .sel_attr(sel_attr), .sel_ppn(sel_ppn)
    );

    dtlb_perm_check u_perm (
        .hit(hit), .attr(sel_attr), .user(req_user), .kind(req_kind),
        .fault(fault_c), .fsw(fsw_c), .rd_ok(rd_c), .wr_ok(wr_c)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_ppn   <= '0;
            rsp_rd_ok <= 1'b0;
            rsp_wr_ok <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_fsw   <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_hit   <= hit;
            rsp_miss  <= !hit;
            rsp_ppn   <= hit ? sel_ppn : '0;
            rsp_rd_ok <= rd_c;
            rsp_wr_ok <= wr_c;
            rsp_fault <= fault_c;
            rsp_fsw   <= fsw_c;
        end
    end

    fsw_t fsw_view;
    assign fsw_view = fsw_t'(rsp_fsw);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);                                          // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_rd_ok && rsp_fault == 2'd0)); // R2
    AST_MISS_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (!rsp_rd_ok && !rsp_wr_ok && rsp_fault == 2'd0)); // R3
    AST_DACC_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault == 2'd1) |-> (fsw_view.priv_cause || fsw_view.sidefx_cause || fsw_view.nfo_cause)); // R8
    AST_PROT_ONLY_STORE: assert property (@(posedge clk) disable iff (rst)
        (rsp_fault == 2'd2) |-> (fsw_view.st_flag && rsp_hit &&
         !fsw_view.priv_cause && !fsw_view.sidefx_cause && !fsw_view.nfo_cause)); // R9
    AST_KIND_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(fsw_view.st_flag && fsw_view.nf_flag));                          // R10
    AST_WR_IMPLIES_RD: assert property (@(posedge clk) disable iff (rst)
        rsp_wr_ok |-> (rsp_rd_ok && rsp_fault == 2'd0));                  // R11
    AST_NF_NO_NFO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fsw_view.nf_flag |-> !fsw_view.nfo_cause);                         // R7

endmodule

// File: tb/dtlb_fault_check_tb.sv
`timescale 1ns/1ps
module dtlb_fault_check_tb;

    localparam int N  = 64;
    localparam int VW = 20;
    localparam int CW = 13;
    localparam int PW = 24;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, req_user = 0, wr_en = 0;
    logic [VW-1:0] req_vpn = 0, wr_vpn = 0;
    logic [CW-1:0] req_ctx = 0, wr_ctx = 0;
    logic [1:0]    req_kind = 0;
    logic [IW-1:0] wr_idx = 0;
    logic [PW-1:0] wr_ppn = 0;
    logic [63:0]   wr_attr = 0;

    logic          rsp_valid, rsp_hit, rsp_miss, rsp_rd_ok, rsp_wr_ok;
    logic [PW-1:0] rsp_ppn;
    logic [1:0]    rsp_fault;
    logic [4:0]    rsp_fsw;

    dtlb_fault_check u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
        .req_ctx(req_ctx), .req_user(req_user), .req_kind(req_kind),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_ctx(wr_ctx),
        .wr_ppn(wr_ppn), .wr_attr(wr_attr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_ppn(rsp_ppn), .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok),
        .rsp_fault(rsp_fault), .rsp_fsw(rsp_fsw)
    );

    // behavioural model
    bit          m_v [N];
    bit [VW-1:0] m_vpn [N];
    bit [CW-1:0] m_ctx [N];
    bit [PW-1:0] m_ppn [N];
    bit [63:0]   m_attr [N];

    bit          e_valid, e_hit, e_rd, e_wr;
    bit [PW-1:0] e_ppn;
    bit [1:0]    e_fault;
    bit [4:0]    e_fsw;

    int vectors = 0;
    int miscompares = 0;

    localparam logic [63:0] A_V   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] A_NFO = 64'h1000_0000_0000_0000;
    localparam logic [63:0] A_SE  = 64'h8;
    localparam logic [63:0] A_PR  = 64'h4;
    localparam logic [63:0] A_WR  = 64'h2;

    task automatic fail_line(input string req, input longint act, input longint exp, inout bit bad);
        $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        bad = 1;
    endtask

    task automatic compare();
        bit bad = 0;
        vectors++;
        if (rsp_valid !== e_valid) fail_line("R2 valid", rsp_valid, e_valid, bad);
        if (rsp_hit !== e_hit) fail_line("R3 hit", rsp_hit, e_hit, bad);
        if (rsp_miss !== (e_valid && !e_hit)) fail_line("R3 miss", rsp_miss, e_valid && !e_hit, bad);
        if (rsp_ppn !== e_ppn) fail_line("R3 ppn", rsp_ppn, e_ppn, bad);
        if (rsp_fault !== e_fault) fail_line("R9 fault code", rsp_fault, e_fault, bad);
        if (rsp_fsw[1:0] !== e_fsw[1:0]) fail_line("R10 kind flags", rsp_fsw[1:0], e_fsw[1:0], bad);
        if (rsp_fsw[4:2] !== e_fsw[4:2]) fail_line("R8 cause bits", rsp_fsw[4:2], e_fsw[4:2], bad);
        if (rsp_rd_ok !== e_rd) fail_line("R11 rd_ok", rsp_rd_ok, e_rd, bad);
        if (rsp_wr_ok !== e_wr) fail_line("R11 wr_ok", rsp_wr_ok, e_wr, bad);
        if (bad) miscompares++;
    endtask

    // expectation from the requirements (R3..R13)
    task automatic predict();
        int idx = -1;
        bit st, nf, c_pr, c_se, c_nfo, dacc, dprot;
        e_valid = req_valid; e_hit = 0; e_rd = 0; e_wr = 0; e_ppn = 0; e_fault = 0; e_fsw = 0;
        if (!req_valid) return;
        for (int i = 0; i < N; i++)
            if (idx < 0 && m_v[i] && m_vpn[i] == req_vpn && m_ctx[i] == req_ctx) idx = i;
        st = (req_kind == 2'b01);
        nf = (req_kind == 2'b10);     // R12: 11 acts as a normal load
        e_fsw[0] = st;
        e_fsw[1] = nf;
        if (idx < 0) return;
        e_hit = 1;
        e_ppn = m_ppn[idx];
        c_pr  = req_user && m_attr[idx][2];
        c_se  = nf && m_attr[idx][3];
        c_nfo = !nf && m_attr[idx][60];
        e_fsw[2] = c_pr; e_fsw[3] = c_se; e_fsw[4] = c_nfo;
        dacc  = c_pr || c_se || c_nfo;
        dprot = !dacc && st && !m_attr[idx][1];
        e_fault = dacc ? 2'd1 : (dprot ? 2'd2 : 2'd0);
        e_rd = !dacc && !dprot;
        e_wr = e_rd && m_attr[idx][1];
    endtask

    // one clock: check previous result, then drive new inputs
    task automatic cycle(input bit rv, input bit [VW-1:0] vpn, input bit [CW-1:0] ctx,
                         input bit usr, input bit [1:0] kind,
                         input bit we, input int widx, input bit [VW-1:0] wv,
                         input bit [CW-1:0] wc, input bit [PW-1:0] wp, input bit [63:0] wa);
        @(negedge clk);
        compare();
        req_valid = rv; req_vpn = vpn; req_ctx = ctx; req_user = usr; req_kind = kind;
        wr_en = we; wr_idx = IW'(widx); wr_vpn = wv; wr_ctx = wc; wr_ppn = wp; wr_attr = wa;
        predict();                      // lookup sees old contents (R4)
        if (we) begin
            m_v[widx]    = wa[63];
            m_vpn[widx]  = wv; m_ctx[widx] = wc;
            m_ppn[widx]  = wp; m_attr[widx] = wa;
        end
    endtask

    task automatic fill(input int idx, input bit [VW-1:0] v, input bit [63:0] a);
        cycle(0, 0, 0, 0, 0, 1, idx, v, 13'd5, PW'(24'h30000 + idx), a);
    endtask

    task automatic look(input bit [VW-1:0] v, input bit usr, input bit [1:0] kind);
        cycle(1, v, 13'd5, usr, kind, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_vpn[i] = 0; m_ctx[i] = 0; m_ppn[i] = 0; m_attr[i] = 0; end
        e_valid = 0; e_hit = 0; e_rd = 0; e_wr = 0; e_ppn = 0; e_fault = 0; e_fsw = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();                                   // R1 during reset
        rst = 0;
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);      // R1 after reset
        look(20'h100, 0, 2'b00);                      // R1 nothing valid after reset: miss

        fill(0, 20'h100, A_V | A_WR | 64'h0000_0200_0000_0041);  // R4 junk bits ignored
        fill(1, 20'h101, A_V | A_PR);
        fill(2, 20'h102, A_V | A_SE | A_WR);
        fill(3, 20'h103, A_V | A_NFO);
        fill(4, 20'h104, A_V | A_NFO | A_PR);
        fill(5, 20'h105, A_NFO | A_WR);              // valid clear
        fill(6, 20'h106, A_V);
        fill(10, 20'h106, A_V | A_WR);

        look(20'h100, 1, 2'b00);   // R11 load ok, writable
        look(20'h100, 1, 2'b01);   // R10 store flag, R11
        look(20'h101, 1, 2'b00);   // R5 user on privileged page
        look(20'h101, 0, 2'b00);   // R11 privileged read, no write
        look(20'h101, 0, 2'b01);   // R9 write protection
        look(20'h102, 0, 2'b10);   // R6 nonfaulting load on side-effect page
        look(20'h102, 0, 2'b00);   // R6 normal load there is fine
        look(20'h103, 0, 2'b00);   // R7 normal load on nonfaulting-only page
        look(20'h103, 0, 2'b10);   // R7 nonfaulting load allowed
        look(20'h103, 0, 2'b01);   // R9 data-access overrides protection
        look(20'h103, 0, 2'b11);   // R12 spare code acts as load
        look(20'h104, 1, 2'b01);   // R8 two causes at once
        look(20'h104, 1, 2'b10);   // R8 privilege only
        look(20'h105, 0, 2'b00);   // R3 invalid entry misses
        cycle(1, 20'h100, 13'd6, 0, 0, 0, 0, 0, 0, 0, 0);  // R3 context mismatch
        look(20'h106, 0, 2'b01);   // R13 lowest index wins
        cycle(1, 20'h107, 13'd5, 0, 0, 1, 7, 20'h107, 13'd5, 24'h777, A_V | A_WR); // R4 same-cycle write
        look(20'h107, 0, 2'b00);   // R4 visible next cycle
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        for (int k = 0; k < 4000; k++) begin
            bit we = ($urandom % 10) < 3;
            bit [63:0] a = {$urandom, $urandom};
            cycle($urandom % 4 != 0, VW'(20'h200 + $urandom % 8), CW'(1 + $urandom % 2),
                  1'($urandom), 2'($urandom),
                  we, int'($urandom % N), VW'(20'h200 + $urandom % 8), CW'(1 + $urandom % 2),
                  PW'($urandom), a);
        end
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule